// File: doc/BRIEF.md
# Two-Key Guarded Register Bank

This block is a memory-mapped register slave whose writable state is shielded by a two-step key handshake. Software must place one 32-bit magic word in a first key slot and then a second, different magic word in a second key slot. Only after that ordered pair has landed does the bank accept writes to its protected contents. The protected contents are three narrow configuration registers, one full-width interrupt-enable register and a small set of 32-bit scratch words. Any wrong value written to either key slot, including zero, closes the bank again.

Reads are never gated. The read data port is combinational on the request address, so a host sees stored contents regardless of the lock state. Requests use a plain valid/write/address/data interface with byte addresses and 32-bit data. A single status output shows whether writes are currently being accepted.

Top module: `keyed_reg_bank`

## Requirements
- R1: After reset the bank is locked (`unlocked` = 0) and every readable address returns zero.
- R2: Writing 0x83E70B13 to the first key slot at byte address 0x6C and then 0x95A4F1E0 to the second key slot at 0x70 raises `unlocked` on the cycle after the second write. Other register accesses may fall between the two key writes.
- R3: Writing the correct second key while no correct first key is pending leaves the bank locked.
- R4: Writing any value other than its magic word (zero included) to either key slot locks the bank from the next cycle.
- R5: Writing the correct first key while the bank is open closes it until the second key is written again.
- R6: While locked, writes to every non-key address are dropped and all stored contents stay unchanged.
- R7: Three 32-bit scratch words sit at 0x60, 0x64 and 0x68 (stride 4). They read at any time and store all 32 written bits when unlocked.
- R8: The interrupt-enable register at 0x04 stores a full 32-bit write. A later 32-bit write with a single bit cleared clears only that bit.
- R9: The control (0x00), oscillator (0x08) and wake-enable (0x0C) registers keep bits 7:0 of a write. Their upper bits read as zero.
- R10: Both key slots and all unmapped or unaligned addresses read as zero, and writes to unmapped addresses change nothing.
- R11: Read requests (`req_write` = 0) never change the lock state, even when they carry a key address and a magic word on `req_wdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data for `req_addr` (combinational) |
| unlocked | output | 1 | 1 while protected writes are accepted |

## Verification
The bench sweeps every word address, once while locked and twice while open using complementary patterns. This exposes a decoder that aliases an address, a narrow register that keeps upper bits, and a gate that leaks a write while locked. It also drives the ordering corner cases: the second key alone, the first key repeated while open, a wrong first key after a correct one, and zero or off-by-one values in either slot. A design with a one-key unlock or a sticky open state would be left open by one of these cases. Read requests that carry a magic word on the data lines must leave the lock alone, so a design that decodes keys without looking at the write flag would unlock there.

// File: rtl/keybank_pkg.sv
// Shared constants and types for the two-key guarded register bank.
// Assumes byte addressing with 32-bit words.
package keybank_pkg;
    localparam int unsigned BANK_ADDR_W = 8;
    localparam int unsigned BANK_DATA_W = 32;

    localparam logic [31:0] KEY_FIRST  = 32'h83E7_0B13;
    localparam logic [31:0] KEY_SECOND = 32'h95A4_F1E0;

    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_IRQEN = 8'h04;
    localparam logic [7:0] OFF_OSC   = 8'h08;
    localparam logic [7:0] OFF_WAKE  = 8'h0C;
    localparam logic [7:0] OFF_SCR0  = 8'h60;
    localparam logic [7:0] OFF_KEYA  = 8'h6C;
    localparam logic [7:0] OFF_KEYB  = 8'h70;

    typedef enum logic [1:0] {
        GUARD_LOCKED = 2'd0,
        GUARD_ARMED  = 2'd1,
        GUARD_OPEN   = 2'd2
    } guard_state_e;
endpackage

// File: rtl/key_guard.sv
// Lock state machine. It watches writes to the two key slots and opens the
// bank only after the ordered magic pair has been written.
// Assumes wr_en is already qualified by valid and write.
module key_guard
    import keybank_pkg::*;
#(
    parameter int unsigned ADDR_W = BANK_ADDR_W,
    parameter int unsigned DATA_W = BANK_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked
);
    localparam logic [ADDR_W-1:0] A_KEYA = ADDR_W'(OFF_KEYA);
    localparam logic [ADDR_W-1:0] A_KEYB = ADDR_W'(OFF_KEYB);
    localparam logic [DATA_W-1:0] K_A    = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] K_B    = DATA_W'(KEY_SECOND);

    guard_state_e state_q, state_d;
    logic hit_a, hit_b;

    assign hit_a = wr_en && (addr == A_KEYA);
    assign hit_b = wr_en && (addr == A_KEYB);

    // Next lock state from key-slot writes.
    always_comb begin
        state_d = state_q;
        if (hit_a) begin
            state_d = (wdata == K_A) ? GUARD_ARMED : GUARD_LOCKED;
        end else if (hit_b) begin
            if (wdata != K_B)
                state_d = GUARD_LOCKED;
            else if (state_q == GUARD_ARMED || state_q == GUARD_OPEN)
                state_d = GUARD_OPEN;
            else
                state_d = GUARD_LOCKED;
        end
    end

    // Lock state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= GUARD_LOCKED;
        else        state_q <= state_d;
    end

    assign unlocked = (state_q == GUARD_OPEN);

    // R2
    pair_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_b && wdata == K_B && state_q == GUARD_ARMED) |=> unlocked);

    // R4
    bad_key_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_a && wdata != K_A) || (hit_b && wdata != K_B)) |=> !unlocked);

    // R3
    lone_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GUARD_LOCKED && !hit_a) |=> !unlocked);

    // R5
    first_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && unlocked) |=> !unlocked);
endmodule

// File: rtl/prot_store.sv
// Protected storage: narrow configuration registers, the full-width
// interrupt-enable register and the scratch words. A write lands only when
// the guard reports the bank open.
// Assumes wr_en is already qualified by valid and write.
module prot_store
    import keybank_pkg::*;
#(
    parameter int unsigned ADDR_W    = BANK_ADDR_W,
    parameter int unsigned DATA_W    = BANK_DATA_W,
    parameter int unsigned NARROW_W  = 8,
    parameter int unsigned N_NARROW  = 3,
    parameter int unsigned N_SCRATCH = 3
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic                                 unlocked,
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [DATA_W-1:0]                    wdata,
    output logic [N_NARROW-1:0][NARROW_W-1:0]    narrow_q,
    output logic [DATA_W-1:0]                    irq_en_q,
    output logic [N_SCRATCH-1:0][DATA_W-1:0]     scratch_q
);
    localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(OFF_IRQEN);
    localparam int unsigned STRIDE = DATA_W / 8;

    logic gated;
    assign gated = wr_en && unlocked;

    // Byte address of narrow register i.
    function automatic logic [ADDR_W-1:0] narrow_off(input int unsigned i);
        case (i)
            0:       return ADDR_W'(OFF_CTRL);
            1:       return ADDR_W'(OFF_OSC);
            default: return ADDR_W'(OFF_WAKE);
        endcase
    endfunction

    for (genvar gi = 0; gi < N_NARROW; gi++) begin : g_narrow
        // Narrow register: keeps the low bits of an accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                narrow_q[gi] <= '0;
            else if (gated && addr == narrow_off(gi))
                narrow_q[gi] <= wdata[NARROW_W-1:0];
        end
    end

    // Interrupt-enable register: full-width store.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_en_q <= '0;
        else if (gated && addr == A_IRQ)
            irq_en_q <= wdata;
    end

    for (genvar gs = 0; gs < N_SCRATCH; gs++) begin : g_scratch
        localparam logic [ADDR_W-1:0] A_SCR = ADDR_W'(OFF_SCR0 + gs * STRIDE);
        // Scratch word: full-width store at its stride slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                scratch_q[gs] <= '0;
            else if (gated && addr == A_SCR)
                scratch_q[gs] <= wdata;
        end
    end

    // R6
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable({narrow_q, irq_en_q, scratch_q}));

    // R8
    irq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && addr == A_IRQ) |=> irq_en_q == $past(wdata));
endmodule

// File: rtl/read_mux.sv
// Read path: selects stored contents by byte address, zero elsewhere.
// Assumes reads are combinational and never gated by the lock.
module read_mux
    import keybank_pkg::*;
#(
    parameter int unsigned ADDR_W    = BANK_ADDR_W,
    parameter int unsigned DATA_W    = BANK_DATA_W,
    parameter int unsigned NARROW_W  = 8,
    parameter int unsigned N_NARROW  = 3,
    parameter int unsigned N_SCRATCH = 3
) (
    input  logic [ADDR_W-1:0]                    addr,
    input  logic [N_NARROW-1:0][NARROW_W-1:0]    narrow_q,
    input  logic [DATA_W-1:0]                    irq_en_q,
    input  logic [N_SCRATCH-1:0][DATA_W-1:0]     scratch_q,
    output logic [DATA_W-1:0]                    rdata
);
    localparam int unsigned STRIDE = DATA_W / 8;

    // Byte address of narrow register i.
    function automatic logic [ADDR_W-1:0] narrow_off(input int unsigned i);
        case (i)
            0:       return ADDR_W'(OFF_CTRL);
            1:       return ADDR_W'(OFF_OSC);
            default: return ADDR_W'(OFF_WAKE);
        endcase
    endfunction

    // Address decode for reads.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_NARROW; i++)
            if (addr == narrow_off(i))
                rdata = DATA_W'(narrow_q[i]);
        if (addr == ADDR_W'(OFF_IRQEN))
            rdata = irq_en_q;
        for (int s = 0; s < N_SCRATCH; s++)
            if (addr == ADDR_W'(OFF_SCR0 + s * STRIDE))
                rdata = scratch_q[s];
    end

    // R9
    always_comb begin
        for (int i = 0; i < N_NARROW; i++)
            if (addr == narrow_off(i))
                narrow_upper_zero_chk: assert (rdata[DATA_W-1:NARROW_W] == '0);
    end
endmodule

// File: rtl/keyed_reg_bank.sv
// Top of the two-key guarded register bank: ties the lock guard, the
// protected storage and the read path together.
// Assumes a single-cycle valid/write/address/data request interface.
module keyed_reg_bank
    import keybank_pkg::*;
#(
    parameter int unsigned ADDR_W    = BANK_ADDR_W,
    parameter int unsigned DATA_W    = BANK_DATA_W,
    parameter int unsigned NARROW_W  = 8,
    parameter int unsigned N_SCRATCH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              unlocked
);
    localparam int unsigned N_NARROW = 3;

    logic wr_en;
    logic [N_NARROW-1:0][NARROW_W-1:0] narrow_q;
    logic [DATA_W-1:0]                 irq_en_q;
    logic [N_SCRATCH-1:0][DATA_W-1:0]  scratch_q;

    assign wr_en = req_valid && req_write;

    key_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(req_addr), .wdata(req_wdata), .unlocked(unlocked)
    );

    prot_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W),
        .N_NARROW(N_NARROW), .N_SCRATCH(N_SCRATCH)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .unlocked(unlocked),
        .addr(req_addr), .wdata(req_wdata),
        .narrow_q(narrow_q), .irq_en_q(irq_en_q), .scratch_q(scratch_q)
    );

    read_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W),
        .N_NARROW(N_NARROW), .N_SCRATCH(N_SCRATCH)
    ) u_rd (
        .addr(req_addr), .narrow_q(narrow_q), .irq_en_q(irq_en_q),
        .scratch_q(scratch_q), .rdata(rsp_rdata)
    );
endmodule

// File: tb/test_keyed_reg_bank.sv
// Self-checking bench: sweeps all word addresses locked and unlocked
// against a bench-side model built from the requirements.
module test_keyed_reg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        unlocked;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [64];

    localparam logic [31:0] KA = 32'h83E7_0B13;
    localparam logic [31:0] KB = 32'h95A4_F1E0;

    always #10 clk = ~clk;

    keyed_reg_bank i_keyed_reg_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .unlocked(unlocked)
    );

    function automatic logic [31:0] wmask(input logic [7:0] a);
        case (a)
            8'h00, 8'h08, 8'h0C:        return 32'h0000_00FF;
            8'h04, 8'h60, 8'h64, 8'h68: return 32'hFFFF_FFFF;
            default:                    return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        req_addr = a; req_valid = 1'b1; req_write = 1'b0;
        #1;
        chk(tag, rsp_rdata, exp);
        req_valid = 1'b0;
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        for (int a = 0; a < 64; a++)
            rd_chk(tag, 8'(a * 4), model[a]);
        for (int u = 1; u < 4; u++)
            rd_chk({tag, " R10 unaligned"}, 8'(u), 32'h0);
    endtask

    task automatic open_bank();
        wr(8'h6C, KA);
        wr(8'h70, KB);
    endtask

    task automatic sweep_write(input logic [31:0] seed, input logic open);
        for (int a = 0; a < 64; a++) begin
            logic [7:0] ad = 8'(a * 4);
            logic [31:0] p = seed ^ (32'(a) * 32'h0101_0101);
            if (ad == 8'h6C || ad == 8'h70) continue;
            wr(ad, p);
            if (open) model[a] = p & wmask(ad);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) model[a] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        chk("R1 lock after reset", 32'(unlocked), 32'h0);
        check_all("R1 reset contents");

        // R6: locked sweep drops everything
        sweep_write(32'hA5A5_3C3C, 1'b0);
        chk("R6 still locked", 32'(unlocked), 32'h0);
        check_all("R6 locked sweep");

        // R11: reads carrying magic words do not unlock
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h6C; req_wdata = KA;
        @(negedge clk); req_addr = 8'h70; req_wdata = KB;
        @(negedge clk); req_valid = 1'b0;
        chk("R11 reads keep lock", 32'(unlocked), 32'h0);

        // R3: second key alone
        wr(8'h70, KB);
        chk("R3 lone second key", 32'(unlocked), 32'h0);

        // R2: ordered pair with traffic in between
        wr(8'h6C, KA);
        chk("R2 armed is locked", 32'(unlocked), 32'h0);
        wr(8'h00, 32'h0000_0077);
        check_all("R6 write while armed");
        wr(8'h70, KB);
        chk("R2 pair opens", 32'(unlocked), 32'h1);

        // R7 R8 R9 R10: open sweeps with complementary patterns
        sweep_write(32'h1234_5678, 1'b1);
        check_all("R7 R8 R9 R10 open sweep A");
        sweep_write(32'hEDCB_A987, 1'b1);
        check_all("R7 R8 R9 R10 open sweep B");

        // R8: clear one bit with a full-width write
        model[1] = model[1] & ~32'h0000_0010;
        wr(8'h04, model[1]);
        rd_chk("R8 single bit clear", 8'h04, model[1]);
        model[1] = 32'hFFFF_FFFF;
        wr(8'h04, 32'hFFFF_FFFF);
        model[1] = 32'hFFFF_FFEF;
        wr(8'h04, 32'hFFFF_FFEF);
        rd_chk("R8 clear bit 4", 8'h04, 32'hFFFF_FFEF);

        // R5: first key while open relocks
        wr(8'h6C, KA);
        chk("R5 first key relocks", 32'(unlocked), 32'h0);
        wr(8'h60, 32'hDEAD_BEEF);
        rd_chk("R5 scratch dropped", 8'h60, model[24]);
        wr(8'h70, KB);
        chk("R5 reopen", 32'(unlocked), 32'h1);

        // R4: wrong values in either slot
        wr(8'h6C, 32'h0);
        chk("R4 zero first slot", 32'(unlocked), 32'h0);
        open_bank();
        wr(8'h70, 32'h0);
        chk("R4 zero second slot", 32'(unlocked), 32'h0);
        open_bank();
        wr(8'h70, KB ^ 32'h1);
        chk("R4 off-by-one second", 32'(unlocked), 32'h0);
        open_bank();
        wr(8'h6C, KA ^ 32'h8000_0000);
        chk("R4 wrong first", 32'(unlocked), 32'h0);
        wr(8'h6C, KA);
        wr(8'h6C, 32'h1);
        wr(8'h70, KB);
        chk("R4 wrong first after armed", 32'(unlocked), 32'h0);
        wr(8'h68, 32'h0BAD_F00D);
        check_all("R6 after relock");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule